// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block watches the address phase of each transfer on an I2C bus and decides whether the local controller is the one being addressed. A bit-level receiver in front of it turns the bus into events: a START (first or repeated), a STOP, and a strobe that marks a complete eight-bit byte. The matcher compares the first byte after each START, and for 10-bit addressing the byte that follows it, against a right-justified 10-bit own address. When they match it raises a single-cycle pulse in time for the acknowledge to be driven on the ninth clock.

An all-zero first byte is a general call. The block accepts it only when the general-call enable is set, and it then raises a general-call flag that stays set until the next START. The read/write direction from the address byte is held on an output for the data-phase logic. When the local controller acts as a master in a system set up with only one master, the compare path is switched off and no match is ever reported.

Top module: `slv_addr_match`

## Requirements
- R1: After reset, match_pulse, gc_flag and dir_read are all 0.
- R2: In 7-bit mode (ten_bit_mode=0), a first byte after START whose bits 7:1 equal own_addr[6:0] gives match_pulse, and dir_read takes bit 0 of that byte. own_addr[9:7] plays no part in the comparison.
- R3: In 7-bit mode, a first byte whose bits 7:1 differ from own_addr[6:0] and that is not a general call gives no match_pulse.
- R4: A first byte equal to 8'h00 gives match_pulse, sets gc_flag and clears dir_read when gc_enable=1. When gc_enable=0 it gives no pulse and leaves gc_flag at 0.
- R5: gc_flag reads 0 in the cycle after any START event.
- R6: In 10-bit mode, a first byte {5'b11110, own_addr[9:8], 1'b0} gives no pulse. When it is followed by a second byte equal to own_addr[7:0], match_pulse fires after that second byte and dir_read becomes 0.
- R7: In 10-bit mode, a wrong second byte, or a first byte whose bits 2:1 differ from own_addr[9:8], gives no match_pulse.
- R8: In 10-bit mode, a first byte {5'b11110, own_addr[9:8], 1'b1} after a repeated START gives match_pulse with dir_read=1 only if a full 10-bit write address matched since the last STOP. Otherwise it gives no pulse.
- R9: While is_master=1 and multi_master_en=0, no byte ever causes match_pulse or sets gc_flag.
- R10: Bytes received before any START, or after the address phase of a transfer, never cause match_pulse.
- R11: match_pulse is high for exactly one cycle, in the cycle that follows the byte_strobe cycle of the matching byte.
- R12: A byte_strobe in the same cycle as start_evt or stop_evt is discarded. After start_evt the next byte is treated as the first address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| own_addr | input | 10 | Right-justified own address |
| ten_bit_mode | input | 1 | 1: own address is 10-bit, 0: 7-bit |
| gc_enable | input | 1 | Accept the general-call address |
| multi_master_en | input | 1 | System has more than one master |
| is_master | input | 1 | Local controller currently acts as master |
| start_evt | input | 1 | START or repeated START seen (one cycle) |
| stop_evt | input | 1 | STOP seen (one cycle) |
| byte_strobe | input | 1 | rx_byte holds a complete byte (one cycle) |
| rx_byte | input | 8 | Received byte, MSB first on the bus |
| match_pulse | output | 1 | One-cycle pulse: this controller was addressed |
| gc_flag | output | 1 | General call received since the last START |
| dir_read | output | 1 | Direction of the last matched address, 1 = read |

## Verification
On every cycle the embedded assertions check the following. The match pulse lasts one cycle and always follows a byte strobe that had no START or STOP beside it. It never appears while the compare path is gated off. The general-call flag is low after each START and rises only with a match while the enable was set. Only the bench's transaction scenarios can show the rest, because those properties depend on the value compared and on the history across bytes. That covers whether the right byte values match, that own_addr[9:7] is ignored in 7-bit mode, the two-byte 10-bit sequence, the repeated-START read that depends on an earlier write match, and the direction captured.

// File: rtl/sam_pkg.sv
// Shared types and constants for the slave address matcher.
// Assumes the I2C byte and the address widths are fixed by the bus protocol.
package sam_pkg;
    localparam int BYTE_W  = 8;
    localparam int OA_W    = 10;
    localparam int SHORT_W = 7;
    localparam int HI_W    = OA_W - BYTE_W;          // own-address bits carried in the 10-bit header
    localparam logic [4:0] TEN_PREFIX = 5'b11110;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,   // no transfer seen since STOP or reset
        PH_FIRST  = 2'd1,   // waiting for first address byte
        PH_SECOND = 2'd2,   // 10-bit: waiting for low address byte
        PH_DONE   = 2'd3    // address phase over, data bytes ignored
    } phase_e;
endpackage

// File: rtl/sam_addr_cmp.sv
// Combinational byte comparators for the address matcher.
// Assumes rx_byte is stable whenever the controller samples the results.
module sam_addr_cmp
    import sam_pkg::*;
(
    input  logic [OA_W-1:0]   own_addr,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              hit_short,
    output logic              hit_gc,
    output logic              hit_hdr,
    output logic              hit_low
);
    localparam int PFX_W = BYTE_W - HI_W - 1;

    // Compare the received byte against every address form.
    always_comb begin
        hit_short = (rx_byte[BYTE_W-1:1] == own_addr[SHORT_W-1:0]);
        hit_gc    = (rx_byte == '0);
        hit_hdr   = (rx_byte[BYTE_W-1 -: PFX_W] == TEN_PREFIX) &&
                    (rx_byte[HI_W:1] == own_addr[OA_W-1:BYTE_W]);
        hit_low   = (rx_byte == own_addr[BYTE_W-1:0]);
    end
endmodule

// File: rtl/sam_phase_ctrl.sv
// Address-phase sequencer: tracks where a transfer is in its address bytes,
// produces the match pulse, general-call flag and captured direction.
// Assumes start_evt, stop_evt and byte_strobe are single-cycle events.
module sam_phase_ctrl
    import sam_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ten_bit_mode,
    input  logic gc_enable,
    input  logic cmp_enable,
    input  logic start_evt,
    input  logic stop_evt,
    input  logic byte_strobe,
    input  logic rx_lsb,
    input  logic hit_short,
    input  logic hit_gc,
    input  logic hit_hdr,
    input  logic hit_low,
    output logic match_pulse,
    output logic gc_flag,
    output logic dir_read
);
    phase_e phase_q;
    logic   ten_ok_q;   // full 10-bit write address matched since last STOP

    // Advance the address phase and register the match results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            ten_ok_q    <= 1'b0;
            match_pulse <= 1'b0;
            gc_flag     <= 1'b0;
            dir_read    <= 1'b0;
        end else begin
            match_pulse <= 1'b0;
            if (start_evt) begin
                phase_q <= PH_FIRST;
                gc_flag <= 1'b0;
            end else if (stop_evt) begin
                phase_q  <= PH_IDLE;
                ten_ok_q <= 1'b0;
            end else if (byte_strobe) begin
                case (phase_q)
                    PH_FIRST: begin
                        phase_q <= PH_DONE;
                        if (cmp_enable) begin
                            if (hit_gc && gc_enable) begin
                                match_pulse <= 1'b1;
                                gc_flag     <= 1'b1;
                                dir_read    <= 1'b0;
                            end else if (!ten_bit_mode && hit_short) begin
                                match_pulse <= 1'b1;
                                dir_read    <= rx_lsb;
                            end else if (ten_bit_mode && hit_hdr && !rx_lsb) begin
                                phase_q  <= PH_SECOND;
                                ten_ok_q <= 1'b0;
                            end else if (ten_bit_mode && hit_hdr && rx_lsb && ten_ok_q) begin
                                match_pulse <= 1'b1;
                                dir_read    <= 1'b1;
                            end
                        end
                    end
                    PH_SECOND: begin
                        phase_q <= PH_DONE;
                        if (cmp_enable && hit_low) begin
                            match_pulse <= 1'b1;
                            dir_read    <= 1'b0;
                            ten_ok_q    <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse);

    // R12
    pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> ($past(byte_strobe) && !$past(start_evt) && !$past(stop_evt)));

    // R9
    gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> $past(cmp_enable));

    // R5
    gc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !gc_flag);

    // R4
    gc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gc_flag) |-> (match_pulse && $past(gc_enable) && !dir_read));
endmodule

// File: rtl/slv_addr_match.sv
// I2C slave address matcher top level: gates the compare path by the
// master/multi-master configuration and wires comparators to the sequencer.
// Assumes configuration inputs change only between transfers.
module slv_addr_match
    import sam_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OA_W-1:0]   own_addr,
    input  logic              ten_bit_mode,
    input  logic              gc_enable,
    input  logic              multi_master_en,
    input  logic              is_master,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              byte_strobe,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              match_pulse,
    output logic              gc_flag,
    output logic              dir_read
);
    logic hit_short, hit_gc, hit_hdr, hit_low;
    logic cmp_enable;

    // Compare unit runs unless this is the only master on the bus.
    always_comb cmp_enable = multi_master_en || !is_master;

    sam_addr_cmp u_cmp (
        .own_addr  (own_addr),
        .rx_byte   (rx_byte),
        .hit_short (hit_short),
        .hit_gc    (hit_gc),
        .hit_hdr   (hit_hdr),
        .hit_low   (hit_low)
    );

    sam_phase_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ten_bit_mode (ten_bit_mode),
        .gc_enable    (gc_enable),
        .cmp_enable   (cmp_enable),
        .start_evt    (start_evt),
        .stop_evt     (stop_evt),
        .byte_strobe  (byte_strobe),
        .rx_lsb       (rx_byte[0]),
        .hit_short    (hit_short),
        .hit_gc       (hit_gc),
        .hit_hdr      (hit_hdr),
        .hit_low      (hit_low),
        .match_pulse  (match_pulse),
        .gc_flag      (gc_flag),
        .dir_read     (dir_read)
    );

    // R9
    gc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!multi_master_en && is_master && $past(!multi_master_en && is_master) && !gc_flag)
            |=> !gc_flag);
endmodule

// File: tb/slv_addr_match_bench.sv
module slv_addr_match_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] own_addr = '0;
    logic       ten_bit_mode = 1'b0, gc_enable = 1'b0, multi_master_en = 1'b0, is_master = 1'b0;
    logic       start_evt = 1'b0, stop_evt = 1'b0, byte_strobe = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       match_pulse, gc_flag, dir_read;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state built from the requirements
    int m_ph = 0;            // 0 idle, 1 first, 2 second, 3 done
    bit m_ten_ok = 0, m_gc = 0, m_dir = 0;

    always #2 clk = ~clk;

    slv_addr_match u_slv_addr_match (
        .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .ten_bit_mode(ten_bit_mode),
        .gc_enable(gc_enable), .multi_master_en(multi_master_en), .is_master(is_master),
        .start_evt(start_evt), .stop_evt(stop_evt), .byte_strobe(byte_strobe),
        .rx_byte(rx_byte), .match_pulse(match_pulse), .gc_flag(gc_flag), .dir_read(dir_read)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit enabled();
        return multi_master_en || !is_master;
    endfunction

    // expected match for one byte, updating the reference state
    function automatic bit model_byte(logic [7:0] b);
        bit m = 0;
        if (m_ph == 1) begin
            m_ph = 3;
            if (enabled()) begin
                if (b == 8'h00 && gc_enable) begin m = 1; m_gc = 1; m_dir = 0; end
                else if (!ten_bit_mode && b[7:1] == own_addr[6:0]) begin m = 1; m_dir = b[0]; end
                else if (ten_bit_mode && b[7:3] == 5'b11110 && b[2:1] == own_addr[9:8]) begin
                    if (!b[0]) begin m_ph = 2; m_ten_ok = 0; end
                    else if (m_ten_ok) begin m = 1; m_dir = 1; end
                end
            end
        end else if (m_ph == 2) begin
            m_ph = 3;
            if (enabled() && b == own_addr[7:0]) begin m = 1; m_dir = 0; m_ten_ok = 1; end
        end
        return m;
    endfunction

    task automatic do_start(string req);
        @(negedge clk); start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0;
        m_ph = 1; m_gc = 0;
        check({req, " gc_flag after START"}, gc_flag, 0);
        check({req, " no pulse on START"}, match_pulse, 0);
    endtask

    task automatic do_stop();
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
        m_ph = 0; m_ten_ok = 0;
    endtask

    task automatic send_byte(logic [7:0] b, string req);
        bit em;
        em = model_byte(b);
        @(negedge clk); byte_strobe = 1'b1; rx_byte = b;
        @(negedge clk); byte_strobe = 1'b0; rx_byte = $urandom;
        check({req, " match_pulse"}, match_pulse, em);
        check({req, " gc_flag"}, gc_flag, m_gc);
        check({req, " dir_read"}, dir_read, m_dir);
        @(negedge clk);
        check("R11 pulse width", match_pulse, 0);
    endtask

    task automatic set_cfg(logic [9:0] oa, bit ten, bit gce, bit mm, bit mst);
        own_addr = oa; ten_bit_mode = ten; gc_enable = gce; multi_master_en = mm; is_master = mst;
    endtask

    function automatic logic [7:0] pick_first();
        logic [7:0] r = 8'($urandom);
        if (!ten_bit_mode)
            case ($urandom % 4)
                0: return {own_addr[6:0], r[0]};
                1: return 8'h00;
                2: return r;
                default: return {own_addr[6:0] ^ 7'h01, r[0]};
            endcase
        case ($urandom % 4)
            0: return {5'b11110, own_addr[9:8], 1'b0};
            1: return {5'b11110, own_addr[9:8], 1'b1};
            2: return {5'b11110, ~own_addr[9:8], r[0]};
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 match_pulse", match_pulse, 0);
        check("R1 gc_flag", gc_flag, 0);
        check("R1 dir_read", dir_read, 0);

        // R10: byte before any START
        set_cfg(10'h3A5, 0, 1, 0, 0);
        send_byte({7'h25, 1'b1}, "R10 before START");

        // R2: 7-bit match, upper bits of own_addr differ
        do_start("R5");
        send_byte({7'h25, 1'b1}, "R2 7-bit read match");
        // R10: data byte after address phase
        send_byte({7'h25, 1'b1}, "R10 data byte");
        do_start("R5");
        send_byte({7'h25, 1'b0}, "R2 7-bit write match");
        // R3
        do_start("R5");
        send_byte({7'h24, 1'b1}, "R3 7-bit mismatch");
        do_stop();

        // R4 + R5
        do_start("R5");
        send_byte(8'h00, "R4 general call enabled");
        check("R4 gc_flag set", gc_flag, 1);
        do_start("R5 gc cleared");
        set_cfg(10'h3A5, 0, 0, 0, 0);
        send_byte(8'h00, "R4 general call disabled");
        do_stop();

        // R6, R8
        set_cfg(10'h2C3, 1, 0, 0, 0);
        do_start("R5");
        send_byte({5'b11110, 2'b10, 1'b0}, "R6 10-bit header");
        send_byte(8'hC3, "R6 10-bit low byte");
        do_start("R5");
        send_byte({5'b11110, 2'b10, 1'b1}, "R8 repeated START read");
        check("R8 dir", dir_read, 1);
        do_stop();
        do_start("R5");
        send_byte({5'b11110, 2'b10, 1'b1}, "R8 read without prior write");
        // R7
        do_start("R5");
        send_byte({5'b11110, 2'b10, 1'b0}, "R7 header");
        send_byte(8'hC2, "R7 wrong low byte");
        do_start("R5");
        send_byte({5'b11110, 2'b01, 1'b0}, "R7 wrong header bits");
        send_byte(8'hC3, "R7 low after wrong header");
        do_stop();

        // R9
        set_cfg(10'h025, 0, 1, 0, 1);
        do_start("R5");
        send_byte({7'h25, 1'b0}, "R9 gated own address");
        do_start("R5");
        send_byte(8'h00, "R9 gated general call");
        do_stop();

        // R12: START with a coincident strobe
        set_cfg(10'h025, 0, 1, 1, 1);
        @(negedge clk); start_evt = 1'b1; byte_strobe = 1'b1; rx_byte = {7'h25, 1'b1};
        @(negedge clk); start_evt = 1'b0; byte_strobe = 1'b0;
        m_ph = 1; m_gc = 0;
        check("R12 strobe with START dropped", match_pulse, 0);
        send_byte({7'h25, 1'b1}, "R12 next byte is first");
        @(negedge clk); stop_evt = 1'b1; byte_strobe = 1'b1; rx_byte = {7'h25, 1'b1};
        @(negedge clk); stop_evt = 1'b0; byte_strobe = 1'b0;
        m_ph = 0; m_ten_ok = 0;
        check("R12 strobe with STOP dropped", match_pulse, 0);

        // constrained random transactions
        for (int i = 0; i < 400; i++) begin
            set_cfg(10'($urandom), 1'($urandom), 1'($urandom),
                    ($urandom % 4) != 0, ($urandom % 3) == 0);
            do_start("R5");
            send_byte(pick_first(), "R2/R4/R6 random first");
            if (ten_bit_mode && ($urandom % 4) != 0)
                send_byte(($urandom % 2) ? own_addr[7:0] : 8'($urandom), "R6/R7 random low");
            if ($urandom % 2)
                send_byte(8'($urandom), "R10 random data");
            if (ten_bit_mode && ($urandom % 2)) begin
                do_start("R5");
                send_byte({5'b11110, own_addr[9:8], 1'b1}, "R8 random repeated read");
            end
            if ($urandom % 4 != 0) do_stop();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule